// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the execute-stage arithmetic-logic unit of a 32-bit load/store RISC core. Each operation reads two operand words, a separate 5-bit shift distance and a 4-bit operation code. It produces one result word and a flag that is high when that word is zero. The datapath is combinational. A single output register follows it, so the block fits into a clocked stream.

Immediate forms of instructions reuse the same datapath. The decoder sign-extends or zero-extends the constant before it reaches operand B. Because of this, subtracting a constant is an add of a negative immediate, and the block needs no separate immediate opcode. NOT is the NOR of an operand with zero.

The operand side and the result side are both valid/ready streams. An operand set is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next edge with `out_valid` high. A result stays on the outputs, unchanged, until an edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. As a result, full throughput is kept when the consumer never stalls, and no operand set is taken while a result would be overwritten.

Top module: `rsa_alu`

## Requirements
- R1: Opcode 0 (add) returns A+B modulo 2^32 and raises no exception.
- R2: Opcode 1 (subtract) returns A-B modulo 2^32. Equal operands give a result of 0 with the zero flag high.
- R3: Opcode 2 returns the bitwise AND of A and B. Opcode 3 returns the bitwise OR of A and B.
- R4: Opcode 4 returns the inverse of (A OR B). With B = 0 this gives the inverse of A.
- R5: Opcode 5 shifts A toward the MSB by `in_shamt` (0 to 31) places and fills the vacated bits with zeros. B is ignored.
- R6: Opcode 6 shifts A toward the LSB by `in_shamt` (0 to 31) places and fills the vacated bits with zeros. B is ignored.
- R7: Opcode 7 returns the full word 1 when A is less than B as two's-complement signed values, and 0 otherwise. Bits 31..1 of the result are always zero.
- R8: `out_zero` is high exactly when the delivered 32-bit result is zero.
- R9: Opcodes 8 to 15 return a result of 0, with the zero flag high.
- R10: An operand set taken on one edge is presented, with `out_valid` high, after the next edge. Results leave in the order the operand sets were taken.
- R11: While `out_valid` is high and `out_ready` is low, `out_result` and `out_zero` stay unchanged and `in_ready` is low. `in_ready` is high whenever `out_valid` is low.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_a | input | 32 | Operand A, also the value that is shifted |
| in_b | input | 32 | Operand B, or an already-extended immediate |
| in_shamt | input | 5 | Shift distance |
| in_op | input | 4 | Operation code (see requirements) |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result word |
| out_zero | output | 1 | High when out_result is zero |

## Verification
The bench goes after signed comparison across the sign boundary, for example 0x80000000 against 0x7FFFFFFF. A design that compared unsigned, or took the sign of a wrapped difference, would return the inverted answer there. Shift distances of 0 and 31 are exercised because an off-by-one stage ordering or an arithmetic fill shows up at those ends. Add and subtract are driven across the wrap point, and unused opcodes are sent to catch a default that leaks a datapath value. Random stalls on `out_ready` test whether a held result changes, or whether a new operand set overwrites a result that has not been drained.

// File: rtl/rsa_alu_pkg.sv
package rsa_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_NOR = 4'd4,
    OP_SLL = 4'd5,
    OP_SRL = 4'd6,
    OP_SLT = 4'd7
  } alu_op_e;
  localparam int OP_W = 4;
endpackage

// File: rtl/rsa_addsub.sv
module rsa_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         lt_signed
);
  logic [W-1:0] b_eff;
  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    // signs differ: the negative operand is smaller; same sign: difference sign decides
    lt_signed = (a[W-1] ^ b[W-1]) ? a[W-1] : sum[W-1];
  end
endmodule

// File: rtl/rsa_shifter.sv
module rsa_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [SW-1:0] shamt,
  input  logic          left,
  output logic [W-1:0]  result
);
  logic [W-1:0] stage [SW+1];
  assign stage[0] = data;
  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int DIST = 1 << i;
    always_comb begin
      if (!shamt[i])  stage[i+1] = stage[i];
      else if (left)  stage[i+1] = stage[i] << DIST;
      else            stage[i+1] = stage[i] >> DIST;
    end
  end
  assign result = stage[SW];
endmodule

// File: rtl/rsa_logic.sv
module rsa_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] result
);
  always_comb begin
    unique case (fn)
      2'd0:    result = a & b;
      2'd1:    result = a | b;
      2'd2:    result = ~(a | b);
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/rsa_alu.sv
module rsa_alu
  import rsa_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [SHW-1:0]    in_shamt,
  input  logic [OP_W-1:0]   in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero
);
  logic [DATA_W-1:0] as_sum, sh_res, lg_res, nxt_res;
  logic              as_lt, is_sub, is_left;
  logic [1:0]        lg_fn;
  logic              take;

  assign is_sub  = (in_op == OP_SUB) || (in_op == OP_SLT);
  assign is_left = (in_op == OP_SLL);

  always_comb begin
    unique case (in_op)
      OP_AND:  lg_fn = 2'd0;
      OP_OR:   lg_fn = 2'd1;
      OP_NOR:  lg_fn = 2'd2;
      default: lg_fn = 2'd3;
    endcase
  end

  rsa_addsub #(.W(DATA_W)) u_addsub (
    .a(in_a), .b(in_b), .sub(is_sub), .sum(as_sum), .lt_signed(as_lt)
  );
  rsa_shifter #(.W(DATA_W), .SW(SHW)) u_shift (
    .data(in_a), .shamt(in_shamt), .left(is_left), .result(sh_res)
  );
  rsa_logic #(.W(DATA_W)) u_logic (
    .a(in_a), .b(in_b), .fn(lg_fn), .result(lg_res)
  );

  always_comb begin
    unique case (in_op)
      OP_ADD, OP_SUB:          nxt_res = as_sum;
      OP_AND, OP_OR, OP_NOR:   nxt_res = lg_res;
      OP_SLL, OP_SRL:          nxt_res = sh_res;
      OP_SLT:                  nxt_res = {{(DATA_W-1){1'b0}}, as_lt};
      default:                 nxt_res = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_result <= nxt_res;
        out_zero   <= (nxt_res == '0);
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_zero)));
  p_no_take_stalled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_ready_when_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0)));
  p_slt_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_SLT) |=> (out_result[DATA_W-1:1] == '0));
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op[3]) |=> (out_result == '0 && out_zero));
endmodule

// File: tb/rsa_alu_bench.sv
module rsa_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic [4:0]  in_shamt = '0;
  logic [3:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_zero;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          was_stall = 0;
  logic [31:0] stall_res;
  bit          was_take = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  rsa_alu u_rsa_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_zero(out_zero)
  );

  function automatic logic [31:0] ref_op(logic [31:0] a, logic [31:0] b,
                                         int sh, int op);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return ~(a | b);
      5: return a << sh;
      6: return a >> sh;
      7: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R6"; 7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, observe, then let the edge happen
  task automatic cycle(output bit accepted);
    #1;
    if (was_take) check(out_valid, "R10", {31'd0, out_valid}, 32'd1);
    if (was_stall)
      check(out_valid && out_result == stall_res, "R11", out_result, stall_res);
    if (out_valid && !out_ready)
      check(!in_ready, "R11", {31'd0, in_ready}, 32'd0);
    if (!out_valid)
      check(in_ready, "R11", {31'd0, in_ready}, 32'd1);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R10", out_result, 32'hx);
      else begin
        logic [31:0] e = exp_q.pop_front();
        string t = tag_q.pop_front();
        check(out_result == e, t, out_result, e);
        check(out_zero == (e == 0), "R8", {31'd0, out_zero}, {31'd0, e == 0});
      end
    end
    accepted  = in_valid && in_ready;
    if (accepted) begin
      exp_q.push_back(ref_op(in_a, in_b, int'(in_shamt), int'(in_op)));
      tag_q.push_back(tag_of(int'(in_op)));
    end
    was_take  = accepted;
    was_stall = out_valid && !out_ready;
    stall_res = out_result;
    @(negedge clk);
  endtask

  task automatic send(logic [31:0] a, logic [31:0] b, int sh, int op, bit rdy);
    bit acc = 0;
    in_valid = 1; in_a = a; in_b = b; in_shamt = sh[4:0]; in_op = op[3:0];
    while (!acc) begin
      out_ready = rdy | ($urandom_range(0, 3) != 0);
      cycle(acc);
    end
    in_valid = 0;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 6))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R12", {31'd0, out_valid}, 32'd0);
    check(in_ready, "R12", {31'd0, in_ready}, 32'd1);
    rst_n = 1;
    @(negedge clk);
    // directed corners
    send(32'hFFFF_FFFF, 32'h1, 0, 0, 1);            // R1 wrap
    send(32'h7FFF_FFFF, 32'h1, 0, 0, 1);            // R1
    send(32'h0, 32'h1, 0, 1, 1);                    // R2 wrap
    send(32'h1234_5678, 32'h1234_5678, 0, 1, 1);    // R2 equal -> zero
    send(32'h0000_0DC0, 32'h0000_3C00, 0, 2, 1);    // R3 and
    send(32'h0000_0DC0, 32'h0000_3C00, 0, 3, 1);    // R3 or
    send(32'h0000_3C00, 32'h0, 0, 4, 1);            // R4 not via nor
    send(32'h8000_0001, 32'hDEAD_BEEF, 0, 5, 1);    // R5 shamt 0
    send(32'h0000_0003, 32'hDEAD_BEEF, 31, 5, 1);   // R5 shamt 31
    send(32'h8000_0001, 32'h0, 31, 6, 1);           // R6 no sign fill
    send(32'hF000_0000, 32'h0, 4, 6, 1);            // R6
    send(32'h8000_0000, 32'h7FFF_FFFF, 0, 7, 1);    // R7 negative < positive
    send(32'h7FFF_FFFF, 32'h8000_0000, 0, 7, 1);    // R7
    send(32'hFFFF_FFFF, 32'h0, 0, 7, 1);            // R7 -1 < 0
    send(32'h5, 32'h5, 0, 7, 1);                    // R7 equal
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 9, 1);    // R9
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 15, 1);   // R9
    // random stream with back-pressure
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 4) == 0) begin
        out_ready = $urandom_range(0, 1);
        cycle(acc);
      end else
        send(pick(), pick(), $urandom_range(0, 31), $urandom_range(0, 15), 0);
    end
    out_ready = 1;
    for (int i = 0; i < 4; i++) cycle(acc);
    check(exp_q.size() == 0, "R10", exp_q.size(), 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule